// File: doc/BRIEF.md
# Branch and Next-PC Resolution Unit

This block sequences the program counter of a 32-bit core with a single branch delay slot. Each time `stepIn` is high, it looks at the current instruction word, the two source operands, a floating-point condition bit and an 8-bit vector condition byte. From these it decides whether a control transfer happens and updates the PC on the clock edge.

A taken transfer does not jump at once. The PC first moves to the delay-slot instruction, and the resolved target is kept in a register. On the next step the PC loads that target and the delay-slot flag clears. In the same cycle as the step, the unit also reports a link write of PC+8 (which register and what value) and flags a misaligned target.

Branch-likely forms that are not taken skip the delay slot. The exception is when the decoder reports, through `slotIsCtlIn`, that the delay-slot instruction is itself a control transfer; that instruction then executes.

Top module: `nextpc_unit`

## Requirements
- R1: After reset `pcOut` equals the reset PC (0 by default), `inSlotOut` is 0 and `targetOut` equals the reset PC.
- R2: A step on an instruction that is not a control transfer advances `pcOut` by 4. With `stepIn` low, `pcOut`, `inSlotOut` and `targetOut` hold their values.
- R3: Primary opcodes 4, 5, 6 and 7 branch when rs==rt, rs!=rt, signed rs<=0 and signed rs>0 respectively. When taken, the PC becomes PC+4, `inSlotOut` becomes 1 and `targetOut` becomes PC+4+(sign-extended instr[15:0] shifted left by 2). On the next step the PC takes `targetOut` and `inSlotOut` returns to 0.
- R4: The likely forms are opcodes 20 to 23, REGIMM codes 2, 3, 18 and 19, and coprocessor condition codes 2 and 3. When one of them is not taken, the PC advances by 8. If `slotIsCtlIn` is 1, it advances by 4 instead.
- R5: Opcode 1 (REGIMM) uses instr[20:16] as the condition code. Codes 0 and 1 test signed rs<0 and rs>=0; codes 2 and 3 are their likely forms; codes 16 to 19 are the linking forms of codes 0 to 3. A linking form writes PC+8 to register 31 whether or not the branch is taken.
- R6: Opcodes 2 and 3 jump to {PC[31:28], instr[25:0], 2'b00}. Opcode 3 also writes PC+8 to register 31.
- R7: Opcode 0 with function 8 jumps to the rs value. Function 9 does the same and writes PC+8 to register instr[15:11], but only when that field is nonzero.
- R8: `addrExcOut` is 1 during a step in which a transfer is taken to a target whose low two bits are nonzero. Otherwise it is 0.
- R9: A step taken while `inSlotOut` is 1 always loads `targetOut` into the PC, even if that instruction is a control transfer, and raises no address exception. A link write requested by that instruction still happens.
- R10: Opcode 17 with instr[25:21]=8 tests `fpuCondIn`. Opcode 18 with instr[25:21]=8 tests bit instr[20:18] of `vccIn`. For both, instr[17:16] selects false, true, false-likely or true-likely (codes 0 to 3).
- R11: An ordinary (non-likely) conditional branch that is not taken advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stepIn | input | 1 | Retire the current instruction this cycle |
| instrIn | input | 32 | Instruction word at `pcOut` |
| rsValIn | input | 32 | Value of the rs source register |
| rtValIn | input | 32 | Value of the rt source register |
| fpuCondIn | input | 1 | Floating-point compare condition |
| vccIn | input | 8 | Vector condition-code byte |
| slotIsCtlIn | input | 1 | Instruction at PC+4 is a jump or branch |
| pcOut | output | 32 | Current program counter |
| inSlotOut | output | 1 | Current instruction is a delay slot |
| targetOut | output | 32 | Deferred transfer target |
| linkWeOut | output | 1 | Link register write strobe |
| linkIdxOut | output | 5 | Link destination register |
| linkDataOut | output | 32 | Link value (PC+8) |
| addrExcOut | output | 1 | Misaligned transfer target |

## Verification
The case hardest to reach from the ports is a control transfer that itself sits in a delay slot. Getting there needs a taken branch first, followed by a linking jump on the very next step. The bench builds exactly that pair and checks three things: the second instruction's link write still appears, the PC follows the first target, and a misaligned register jump in that slot raises no exception. Every scenario starts from a known PC, which the bench sets by running a register jump and then its delay slot. This lets the sweeps over branch conditions, operand signs, likely-skip choices and condition-bit selects all begin from a fixed address.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;
  localparam int INSTR_W = 32;

  typedef enum logic [1:0] {
    TGT_REL = 2'd0,
    TGT_ABS = 2'd1,
    TGT_REG = 2'd2
  } tgtSel_e;

  typedef struct packed {
    logic    isCtl;
    logic    taken;
    logic    likely;
    logic    doLink;
    logic    linkToRd;
    tgtSel_e tgtSel;
  } ctrlStrobes_t;

  localparam logic [5:0] OP_SPECIAL = 6'd0;
  localparam logic [5:0] OP_REGIMM  = 6'd1;
  localparam logic [5:0] OP_JMP     = 6'd2;
  localparam logic [5:0] OP_JMPL    = 6'd3;
  localparam logic [5:0] OP_FPC     = 6'd17;
  localparam logic [5:0] OP_VEC     = 6'd18;
  localparam logic [5:0] FN_JREG    = 6'd8;
  localparam logic [5:0] FN_JREGL   = 6'd9;
  localparam logic [4:0] RS_CONDBR  = 5'd8;
  localparam logic [4:0] LINK_REG   = 5'd31;
endpackage

// File: rtl/nextpc_ctrl.sv
module nextpc_ctrl
  import nextpc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int VCC_W = 8
) (
  input  logic [5:0]       opIn,
  input  logic [4:0]       rsFieldIn,
  input  logic [4:0]       rtFieldIn,
  input  logic [5:0]       fnIn,
  input  logic [XLEN-1:0]  rsVal,
  input  logic [XLEN-1:0]  rtVal,
  input  logic             fpuCond,
  input  logic [VCC_W-1:0] vcc,
  output ctrlStrobes_t     strobes
);
  localparam int VSEL_W = $clog2(VCC_W);

  logic isEq, isLez, isNeg, relCond, coCond;
  logic [VSEL_W-1:0] vSel;

  assign isEq  = (rsVal == rtVal);
  assign isNeg = rsVal[XLEN-1];
  assign isLez = isNeg | (rsVal == '0);
  assign vSel  = rtFieldIn[4 -: VSEL_W];

  always_comb begin
    case (opIn[1:0])
      2'd0:    relCond = isEq;
      2'd1:    relCond = ~isEq;
      2'd2:    relCond = isLez;
      default: relCond = ~isLez;
    endcase
    coCond = (opIn == OP_FPC) ? fpuCond : vcc[vSel];
  end

  always_comb begin
    strobes = '0;
    strobes.tgtSel = TGT_REL;
    case (opIn)
      OP_SPECIAL: begin
        if (fnIn == FN_JREG || fnIn == FN_JREGL) begin
          strobes.isCtl    = 1'b1;
          strobes.taken    = 1'b1;
          strobes.tgtSel   = TGT_REG;
          strobes.doLink   = (fnIn == FN_JREGL);
          strobes.linkToRd = (fnIn == FN_JREGL);
        end
      end
      OP_REGIMM: begin
        if (rtFieldIn[3:2] == 2'b00) begin
          strobes.isCtl  = 1'b1;
          strobes.taken  = rtFieldIn[0] ? ~isNeg : isNeg;
          strobes.likely = rtFieldIn[1];
          strobes.doLink = rtFieldIn[4];
        end
      end
      OP_JMP, OP_JMPL: begin
        strobes.isCtl  = 1'b1;
        strobes.taken  = 1'b1;
        strobes.tgtSel = TGT_ABS;
        strobes.doLink = (opIn == OP_JMPL);
      end
      6'd4, 6'd5, 6'd6, 6'd7, 6'd20, 6'd21, 6'd22, 6'd23: begin
        strobes.isCtl  = 1'b1;
        strobes.taken  = relCond;
        strobes.likely = opIn[4];
      end
      OP_FPC, OP_VEC: begin
        if (rsFieldIn == RS_CONDBR) begin
          strobes.isCtl  = 1'b1;
          strobes.taken  = rtFieldIn[0] ? coCond : ~coCond;
          strobes.likely = rtFieldIn[1];
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/nextpc_dp.sv
module nextpc_dp
  import nextpc_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            stepIn,
  input  ctrlStrobes_t    strobes,
  input  logic [25:0]     idxIn,
  input  logic [XLEN-1:0] rsVal,
  input  logic            slotIsCtl,
  output logic [XLEN-1:0] pcQ,
  output logic            slotQ,
  output logic [XLEN-1:0] tgtQ,
  output logic            linkWe,
  output logic [4:0]      linkIdx,
  output logic [XLEN-1:0] linkData,
  output logic            addrExc
);
  localparam int SEXT_W = XLEN - 18;

  logic [XLEN-1:0] pcPlus4, pcPlus8, relTgt, absTgt, selTgt;
  logic [15:0]     imm;
  logic [4:0]      rdField;
  logic            goTaken;

  assign imm     = idxIn[15:0];
  assign rdField = idxIn[15:11];
  assign pcPlus4 = pcQ + XLEN'(4);
  assign pcPlus8 = pcQ + XLEN'(8);
  assign relTgt  = pcPlus4 + {{SEXT_W{imm[15]}}, imm, 2'b00};
  assign absTgt  = {pcQ[XLEN-1 -: 4], idxIn, 2'b00};

  always_comb begin
    case (strobes.tgtSel)
      TGT_ABS: selTgt = absTgt;
      TGT_REG: selTgt = rsVal;
      default: selTgt = relTgt;
    endcase
  end

  assign goTaken  = ~slotQ & strobes.isCtl & strobes.taken;
  assign linkWe   = stepIn & strobes.doLink & (~strobes.linkToRd | (rdField != 5'd0));
  assign linkIdx  = strobes.linkToRd ? rdField : LINK_REG;
  assign linkData = pcPlus8;
  assign addrExc  = stepIn & goTaken & (selTgt[1:0] != 2'b00);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ   <= XLEN'(RESET_PC);
      tgtQ  <= XLEN'(RESET_PC);
      slotQ <= 1'b0;
    end else if (stepIn) begin
      if (slotQ) begin
        pcQ   <= tgtQ;
        slotQ <= 1'b0;
      end else if (goTaken) begin
        pcQ   <= pcPlus4;
        tgtQ  <= selTgt;
        slotQ <= 1'b1;
      end else if (strobes.isCtl && strobes.likely) begin
        pcQ <= slotIsCtl ? pcPlus4 : pcPlus8;
      end else begin
        pcQ <= pcPlus4;
      end
    end
  end
endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
  import nextpc_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          VCC_W    = 8,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               stepIn,
  input  logic [31:0]        instrIn,
  input  logic [XLEN-1:0]    rsValIn,
  input  logic [XLEN-1:0]    rtValIn,
  input  logic               fpuCondIn,
  input  logic [VCC_W-1:0]   vccIn,
  input  logic               slotIsCtlIn,
  output logic [XLEN-1:0]    pcOut,
  output logic               inSlotOut,
  output logic [XLEN-1:0]    targetOut,
  output logic               linkWeOut,
  output logic [4:0]         linkIdxOut,
  output logic [XLEN-1:0]    linkDataOut,
  output logic               addrExcOut
);
  ctrlStrobes_t strobes;

  nextpc_ctrl #(.XLEN(XLEN), .VCC_W(VCC_W)) u_ctrl (
    .opIn      (instrIn[31:26]),
    .rsFieldIn (instrIn[25:21]),
    .rtFieldIn (instrIn[20:16]),
    .fnIn      (instrIn[5:0]),
    .rsVal     (rsValIn),
    .rtVal     (rtValIn),
    .fpuCond   (fpuCondIn),
    .vcc       (vccIn),
    .strobes   (strobes)
  );

  nextpc_dp #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stepIn    (stepIn),
    .strobes   (strobes),
    .idxIn     (instrIn[25:0]),
    .rsVal     (rsValIn),
    .slotIsCtl (slotIsCtlIn),
    .pcQ       (pcOut),
    .slotQ     (inSlotOut),
    .tgtQ      (targetOut),
    .linkWe    (linkWeOut),
    .linkIdx   (linkIdxOut),
    .linkData  (linkDataOut),
    .addrExc   (addrExcOut)
  );
endmodule

// File: rtl/nextpc_chk.sv
module nextpc_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            stepIn,
  input logic [XLEN-1:0] pcOut,
  input logic            inSlotOut,
  input logic [XLEN-1:0] targetOut,
  input logic            linkWeOut,
  input logic [4:0]      linkIdxOut,
  input logic            addrExcOut
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !stepIn |=> ($stable(pcOut) && $stable(inSlotOut) && $stable(targetOut)));

  p_slot_resolve_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stepIn && inSlotOut) |=> (!inSlotOut && pcOut == $past(targetOut)));

  p_slot_no_exc_r9: assert property (@(posedge clk) disable iff (!rstN)
    addrExcOut |-> !inSlotOut);

  p_exc_target_r8: assert property (@(posedge clk) disable iff (!rstN)
    addrExcOut |=> (inSlotOut && targetOut[1:0] != 2'b00));

  p_link_nonzero_r7: assert property (@(posedge clk) disable iff (!rstN)
    linkWeOut |-> (linkIdxOut != 5'd0));
endmodule

bind nextpc_unit nextpc_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .stepIn     (stepIn),
  .pcOut      (pcOut),
  .inSlotOut  (inSlotOut),
  .targetOut  (targetOut),
  .linkWeOut  (linkWeOut),
  .linkIdxOut (linkIdxOut),
  .addrExcOut (addrExcOut)
);

// File: tb/nextpc_unit_tb.sv
`timescale 1ns/1ps
module nextpc_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stepIn = 1'b0;
  logic [31:0] instrIn = '0, rsValIn = '0, rtValIn = '0;
  logic        fpuCondIn = 1'b0, slotIsCtlIn = 1'b0;
  logic [7:0]  vccIn = '0;
  logic [31:0] pcOut, targetOut, linkDataOut;
  logic        inSlotOut, linkWeOut, addrExcOut;
  logic [4:0]  linkIdxOut;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  nextpc_unit u_dut (
    .clk(clk), .rstN(rstN), .stepIn(stepIn), .instrIn(instrIn),
    .rsValIn(rsValIn), .rtValIn(rtValIn), .fpuCondIn(fpuCondIn),
    .vccIn(vccIn), .slotIsCtlIn(slotIsCtlIn), .pcOut(pcOut),
    .inSlotOut(inSlotOut), .targetOut(targetOut), .linkWeOut(linkWeOut),
    .linkIdxOut(linkIdxOut), .linkDataOut(linkDataOut), .addrExcOut(addrExcOut)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkI(input int op, input int rs, input int rt, input logic [15:0] imm);
    return {op[5:0], rs[4:0], rt[4:0], imm};
  endfunction

  task automatic model(input logic [31:0] ins, input logic [31:0] rsv, input logic [31:0] rtv,
                       input logic fc, input logic [7:0] vcc, input logic [31:0] pc,
                       output bit isCtl, output bit taken, output bit likely,
                       output bit lnk, output logic [4:0] lidx, output logic [31:0] tgt);
    int op;
    logic [4:0] rt, rs, rd;
    logic [31:0] rel;
    bit v;
    op = int'(ins[31:26]); rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    rel = pc + 32'd4 + {{14{ins[15]}}, ins[15:0], 2'b00};
    isCtl = 0; taken = 0; likely = 0; lnk = 0; lidx = 5'd31; tgt = rel;
    if (op == 0 && (ins[5:0] == 6'd8 || ins[5:0] == 6'd9)) begin
      isCtl = 1; taken = 1; tgt = rsv;
      if (ins[5:0] == 6'd9) begin lnk = (rd != 0); lidx = rd; end
    end else if (op == 1 && rt[3:2] == 0) begin
      isCtl = 1; likely = rt[1]; lnk = rt[4];
      taken = rt[0] ? ($signed(rsv) >= 0) : ($signed(rsv) < 0);
    end else if (op == 2 || op == 3) begin
      isCtl = 1; taken = 1; lnk = (op == 3); tgt = {pc[31:28], ins[25:0], 2'b00};
    end else if ((op >= 4 && op <= 7) || (op >= 20 && op <= 23)) begin
      isCtl = 1; likely = (op >= 20);
      case (op % 4)
        0: taken = (rsv == rtv);
        1: taken = (rsv != rtv);
        2: taken = ($signed(rsv) <= 0);
        default: taken = ($signed(rsv) > 0);
      endcase
    end else if ((op == 17 || op == 18) && rs == 5'd8) begin
      isCtl = 1; likely = rt[1];
      v = (op == 17) ? fc : vcc[ins[20:18]];
      taken = rt[0] ? v : !v;
    end
  endtask

  task automatic doStep(input logic [31:0] ins, input logic [31:0] rsv, input logic [31:0] rtv,
                        input logic fc, input logic [7:0] vcc, input logic sctl);
    @(negedge clk);
    instrIn = ins; rsValIn = rsv; rtValIn = rtv; fpuCondIn = fc; vccIn = vcc;
    slotIsCtlIn = sctl; stepIn = 1'b1;
    #1;
  endtask

  task automatic finishStep();
    @(posedge clk); #2;
    stepIn = 1'b0;
  endtask

  task automatic setPc(input logic [31:0] p);
    doStep(32'h0000_0008, p, 0, 0, 0, 0); finishStep();
    doStep(32'h0, 0, 0, 0, 0, 0); finishStep();
  endtask

  task automatic runOne(input logic [31:0] ins, input logic [31:0] rsv, input logic [31:0] rtv,
                        input logic fc, input logic [7:0] vcc, input logic sctl,
                        input logic [31:0] pc0, input string tag);
    bit isCtl, taken, likely, lnk;
    logic [4:0] lidx;
    logic [31:0] tgt, expPc;
    setPc(pc0);
    model(ins, rsv, rtv, fc, vcc, pc0, isCtl, taken, likely, lnk, lidx, tgt);
    expPc = (isCtl && !taken && likely) ? (sctl ? pc0 + 4 : pc0 + 8) : pc0 + 4;
    doStep(ins, rsv, rtv, fc, vcc, sctl);
    chk(linkWeOut == lnk, {tag, " link strobe"}, 32'(linkWeOut), 32'(lnk));
    if (lnk) begin
      chk(linkIdxOut == lidx, {tag, " link index"}, 32'(linkIdxOut), 32'(lidx));
      chk(linkDataOut == pc0 + 8, {tag, " link data"}, linkDataOut, pc0 + 8);
    end
    chk(addrExcOut == (taken && tgt[1:0] != 0), {tag, " R8 exception"}, 32'(addrExcOut),
        32'(taken && tgt[1:0] != 0));
    finishStep();
    chk(pcOut == expPc, {tag, " next pc"}, pcOut, expPc);
    chk(inSlotOut == taken, {tag, " slot flag"}, 32'(inSlotOut), 32'(taken));
    if (taken) begin
      chk(targetOut == tgt, {tag, " target"}, targetOut, tgt);
      doStep(32'h0, 0, 0, 0, 0, 0); finishStep();
      chk(pcOut == tgt && !inSlotOut, {tag, " R3 resolve"}, pcOut, tgt);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] vals [5];
    logic [31:0] p;
    vals[0] = 32'h0; vals[1] = 32'h1; vals[2] = 32'hFFFF_FFFF;
    vals[3] = 32'h8000_0000; vals[4] = 32'h5;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk(pcOut == 0, "R1 reset pc", pcOut, 0);
    chk(inSlotOut == 0 && targetOut == 0, "R1 reset slot/target", targetOut, 0);
    rstN = 1'b1;
    // R2 hold without step
    repeat (2) @(posedge clk);
    #2;
    chk(pcOut == 0, "R2 hold", pcOut, 0);
    // R2 non-control
    runOne(mkI(9, 3, 4, 16'h1234), 1, 2, 0, 0, 0, 32'h0000_2000, "R2");
    // R3 R11 R4 relative branches
    for (int oi = 0; oi < 8; oi++)
      for (int a = 0; a < 5; a++)
        for (int b = 0; b < 5; b++)
          for (int s = 0; s < 2; s++)
            runOne(mkI(oi < 4 ? 4 + oi : 16 + oi, 1, 2, 16'(a * 7 - 20)),
                   vals[a], vals[b], 0, 0, s[0], 32'h0040_0100, "R3 R4 R11");
    // R5 REGIMM
    for (int ci = 0; ci < 8; ci++)
      for (int a = 0; a < 5; a++)
        for (int s = 0; s < 2; s++)
          runOne(mkI(1, 6, (ci < 4) ? ci : ci + 12, 16'hFFF0), vals[a], 0, 0, 0, s[0],
                 32'h0080_0400, "R5 R4");
    // R10 FPU and vector condition branches
    for (int c = 0; c < 4; c++)
      for (int f = 0; f < 2; f++)
        for (int s = 0; s < 2; s++)
          runOne(mkI(17, 8, c, 16'h0010), 0, 0, f[0], 0, s[0], 32'h0000_3000, "R10 fpu");
    for (int sel = 0; sel < 8; sel++)
      for (int c = 0; c < 4; c++) begin
        runOne(mkI(18, 8, sel * 4 + c, 16'h0020), 0, 0, 0, 8'hA5, 0, 32'h0000_3100, "R10 vec");
        runOne(mkI(18, 8, sel * 4 + c, 16'h0020), 0, 0, 0, 8'h5A, 1, 32'h0000_3100, "R10 vec");
      end
    // R6 J / JAL
    runOne({6'd2, 26'h123_4567}, 0, 0, 0, 0, 0, 32'hA000_0040, "R6 j");
    runOne({6'd3, 26'h3FF_FFFF}, 0, 0, 0, 0, 0, 32'h5000_0080, "R6 jal");
    // R7 R8 JR / JALR
    for (int t = 0; t < 3; t++) begin
      p = 32'h0000_1000 + 32'(t);
      runOne(32'h0000_0008, p, 0, 0, 0, 0, 32'h0000_0500, "R7 R8 jr");
      runOne({6'd0, 5'd1, 5'd0, 5'd7, 5'd0, 6'd9}, p, 0, 0, 0, 0, 32'h0000_0600, "R7 R8 jalr");
      runOne({6'd0, 5'd1, 5'd0, 5'd0, 5'd0, 6'd9}, p, 0, 0, 0, 0, 32'h0000_0700, "R7 jalr rd0");
    end
    // R9 linking jump in delay slot: link written, control not redirected
    setPc(32'h0000_4000);
    doStep(mkI(4, 1, 2, 16'h0040), 7, 7, 0, 0, 0); finishStep();
    doStep({6'd3, 26'h000_0100}, 0, 0, 0, 0, 0);
    chk(linkWeOut && linkIdxOut == 31, "R9 slot link strobe", 32'(linkWeOut), 1);
    chk(linkDataOut == 32'h0000_400C, "R9 slot link data", linkDataOut, 32'h0000_400C);
    chk(!addrExcOut, "R9 slot no exception", 32'(addrExcOut), 0);
    finishStep();
    chk(pcOut == 32'h0000_4104 && !inSlotOut, "R9 slot target kept", pcOut, 32'h0000_4104);
    // R9 misaligned register jump in slot: no exception, no redirect
    setPc(32'h0000_5000);
    doStep(mkI(5, 1, 2, 16'h0008), 1, 2, 0, 0, 0); finishStep();
    doStep(32'h0000_0008, 32'h0000_0003, 0, 0, 0, 0);
    chk(!addrExcOut, "R9 slot misaligned no exception", 32'(addrExcOut), 0);
    finishStep();
    chk(pcOut == 32'h0000_5024 && !inSlotOut, "R9 slot misaligned pc", pcOut, 32'h0000_5024);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule